// File: doc/BRIEF.md
# Global-History Hashed Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps one shift register that holds the outcomes of the most recent resolved branches, from every branch in the program. It combines that history with the word-address bits of the branch by a bitwise XOR, and the result selects one entry in a table of 2-bit saturating counters. Branches that run in the same history context can then share or separate entries. The fetch stage gets the prediction back in the same cycle it presents the branch address.

The predict port also returns the history value that was in force when the prediction was made. The pipeline carries that value with the branch. When the branch resolves, it sends the value back with the branch address and the actual direction. The block trains the counter that the prediction used and shifts the outcome into the live history at the least significant end. Defaults are 10 history bits and 10 address bits (address bits [11:2] of a word-aligned address), which gives a 1024-entry table.

Top module: `gshare_predictor`

## Requirements
- R1: The history register is HIST_W bits wide. Each accepted update shifts it left by one and puts the resolved direction (1 = taken) in bit 0. Without an update it keeps its value. The predict port shows its current value on `pred_hist`.
- R2: The predictor is indexed by the ADDR_BITS address bits presented, here word-address bits [11:2]. Each of these bits takes part in the index, so flipping any one of them selects a different table entry.
- R3: The table index for a prediction is the presented address field XOR the current history, with both zero-extended to max(HIST_W, ADDR_BITS) bits. The table has 2^max(HIST_W, ADDR_BITS) entries.
- R4: Each entry is a 2-bit counter. A taken update adds one and stops at 3. A not-taken update subtracts one and stops at 0.
- R5: The predicted direction is taken when the selected counter is 2 or 3, and not taken when it is 0 or 1.
- R6: An update trains the entry selected by `upd_addr` XOR `upd_hist`, the history sent back with the update, and not the live history.
- R7: A synchronous reset sets every counter to 1 (weakly not taken) and clears the history to 0.
- R8: The prediction is combinational from `pred_addr` and the state. When a prediction and an update hit the same entry in one cycle, the prediction shows the value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_addr | input | ADDR_BITS (bits [ADDR_LSB+ADDR_BITS-1:ADDR_LSB]) | Word-address field of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | History used for this prediction, kept by the pipeline for the update |
| upd_valid | input | 1 | A branch has resolved this cycle |
| upd_addr | input | ADDR_BITS (bits [ADDR_LSB+ADDR_BITS-1:ADDR_LSB]) | Word-address field of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_hist | input | HIST_W | History value returned with the prediction of this branch |

## Verification
After reset, a sweep over all 1024 addresses checks that every entry predicts not taken and that the history reads zero. Directed runs then drive one entry up into saturation and back down again, which tells the counter thresholds apart from the saturation limits. Other runs send an update whose returned history differs from the live one, and present a prediction and an update to the same entry in one cycle; these show whether the trained entry and the reported value come from the right history and the right cycle. A long pseudo-random stream of addresses, outcomes and returned histories, mostly biased toward taken, is checked every cycle against an arithmetic model of the table and the history, which separates the XOR index from an index built on the address alone.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

  typedef logic [1:0] ctr_t;

  // weakly not-taken starting point for every counter
  localparam ctr_t CTR_INIT = 2'd1;
  localparam ctr_t CTR_MAX  = 2'd3;
  localparam ctr_t CTR_MIN  = 2'd0;

  // saturating up/down step of one counter
  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    ctr_t n;
    if (taken) n = (c == CTR_MAX) ? c : c + 2'd1;
    else       n = (c == CTR_MIN) ? c : c - 2'd1;
    return n;
  endfunction

  // upper half of the count range predicts taken
  function automatic logic ctr_dir(input ctr_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/gshare_history.sv
module gshare_history #(
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist_q
);

  generate
    if (HIST_W == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= shift_bit;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], shift_bit};
      end

      // R1: older outcomes move up by one place on an update
      a_r1_shift_up: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]));
    end
  endgenerate

  // R1: the newest outcome lands in bit 0
  a_r1_newest_lsb: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> hist_q[0] == $past(shift_bit));

  // R1: no update, no change
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/gshare_index_hash.sv
module gshare_index_hash #(
  parameter int HIST_W    = 10,
  parameter int ADDR_BITS = 10,
  parameter int IDX_W     = 10
) (
  input  logic [ADDR_BITS-1:0] addr_field,
  input  logic [HIST_W-1:0]    hist,
  output logic [IDX_W-1:0]     idx
);

  logic [IDX_W-1:0] addr_ext;
  logic [IDX_W-1:0] hist_ext;

  generate
    if (ADDR_BITS == IDX_W) begin : g_addr_full
      assign addr_ext = addr_field;
    end else begin : g_addr_pad
      assign addr_ext = {{(IDX_W-ADDR_BITS){1'b0}}, addr_field};
    end
    if (HIST_W == IDX_W) begin : g_hist_full
      assign hist_ext = hist;
    end else begin : g_hist_pad
      assign hist_ext = {{(IDX_W-HIST_W){1'b0}}, hist};
    end
  endgenerate

  assign idx = addr_ext ^ hist_ext;

endmodule

// File: rtl/gshare_pht.sv
module gshare_pht
  import gshare_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int ENTRIES = 1 << IDX_W;

  ctr_t cnt_q [ENTRIES];
  ctr_t wr_old;

  assign rd_ctr = cnt_q[rd_idx];
  assign wr_old = cnt_q[wr_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) cnt_q[i] <= CTR_INIT;
    end else if (wr_en) begin
      cnt_q[wr_idx] <= ctr_step(wr_old, wr_taken);
    end
  end

  // R4: a taken outcome never lowers the trained counter
  a_r4_taken_no_drop: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken) |=> cnt_q[$past(wr_idx)] >= $past(wr_old));

  // R4: a not-taken outcome never raises the trained counter
  a_r4_nt_no_rise: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken) |=> cnt_q[$past(wr_idx)] <= $past(wr_old));

  // R4: a taken update below the top moves the counter up by exactly one
  a_r4_taken_step: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && wr_old != CTR_MAX) |=>
      cnt_q[$past(wr_idx)] == $past(wr_old) + 2'd1);

  // R4: a not-taken update above the floor moves the counter down by exactly one
  a_r4_nt_step: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && wr_old != CTR_MIN) |=>
      cnt_q[$past(wr_idx)] == $past(wr_old) - 2'd1);

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
  import gshare_pkg::*;
#(
  parameter int HIST_W    = 10,
  parameter int ADDR_BITS = 10,
  parameter int ADDR_LSB  = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [ADDR_LSB+ADDR_BITS-1:ADDR_LSB] pred_addr,
  output logic                                pred_taken,
  output logic [HIST_W-1:0]                   pred_hist,
  input  logic                                upd_valid,
  input  logic [ADDR_LSB+ADDR_BITS-1:ADDR_LSB] upd_addr,
  input  logic                                upd_taken,
  input  logic [HIST_W-1:0]                   upd_hist
);

  localparam int IDX_W = (HIST_W > ADDR_BITS) ? HIST_W : ADDR_BITS;

  logic [HIST_W-1:0]    ghist_q;
  logic [IDX_W-1:0]     rd_idx;
  logic [IDX_W-1:0]     wr_idx;
  logic [ADDR_BITS-1:0] pred_field;
  logic [ADDR_BITS-1:0] upd_field;
  ctr_t                 rd_ctr;

  assign pred_field = pred_addr;
  assign upd_field  = upd_addr;

  gshare_history #(.HIST_W(HIST_W)) hist_i (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (upd_valid),
    .shift_bit (upd_taken),
    .hist_q    (ghist_q)
  );

  gshare_index_hash #(.HIST_W(HIST_W), .ADDR_BITS(ADDR_BITS), .IDX_W(IDX_W)) rd_hash_i (
    .addr_field (pred_field),
    .hist       (ghist_q),
    .idx        (rd_idx)
  );

  gshare_index_hash #(.HIST_W(HIST_W), .ADDR_BITS(ADDR_BITS), .IDX_W(IDX_W)) wr_hash_i (
    .addr_field (upd_field),
    .hist       (upd_hist),
    .idx        (wr_idx)
  );

  gshare_pht #(.IDX_W(IDX_W)) pht_i (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (rd_idx),
    .rd_ctr   (rd_ctr),
    .wr_en    (upd_valid),
    .wr_idx   (wr_idx),
    .wr_taken (upd_taken)
  );

  assign pred_taken = ctr_dir(rd_ctr);
  assign pred_hist  = ghist_q;

  // R5/R8: with no update the prediction for a held address is unchanged
  a_r8_steady_pred: assert property (@(posedge clk) disable iff (rst)
    (!upd_valid && $stable(pred_addr)) |-> $stable(pred_taken) || $past(upd_valid) || $past(rst));

  // R1: the reported history changes only after an update
  a_r1_hist_port: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(pred_hist));

endmodule

// File: tb/gshare_predictor_tb_top.sv
`timescale 1ns/1ps
module gshare_predictor_tb_top;

  localparam int HW = 10;
  localparam int AW = 10;
  localparam int NE = 1024;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [11:2]   pred_addr = '0;
  logic          pred_taken;
  logic [HW-1:0] pred_hist;
  logic          upd_valid = 1'b0;
  logic [11:2]   upd_addr = '0;
  logic          upd_taken = 1'b0;
  logic [HW-1:0] upd_hist = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int unsigned   cnt_m [NE];
  logic [HW-1:0] ghr_m;
  logic [31:0]   lfsr = 32'hACE1_2357;

  always #2 clk = ~clk;

  gshare_predictor dut_i (
    .clk(clk), .rst(rst), .pred_addr(pred_addr), .pred_taken(pred_taken),
    .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_addr(upd_addr),
    .upd_taken(upd_taken), .upd_hist(upd_hist)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check before the edge, advance the model after it
  task automatic cyc(input logic [9:0] pa, input bit uv, input logic [9:0] ua,
                     input bit ut, input logic [9:0] uh, input string req);
    int pidx;
    int widx;
    @(negedge clk);
    pred_addr = pa; upd_valid = uv; upd_addr = ua; upd_taken = ut; upd_hist = uh;
    #1;
    pidx = int'(pa ^ ghr_m);
    chk(pred_taken == (cnt_m[pidx] >= 2), req, int'(pred_taken), int'(cnt_m[pidx] >= 2));
    chk(pred_hist == ghr_m, {req, " (R1 history)"}, int'(pred_hist), int'(ghr_m));
    @(posedge clk);
    if (uv) begin
      widx = int'(ua ^ uh);
      if (ut && cnt_m[widx] < 3) cnt_m[widx]++;
      else if (!ut && cnt_m[widx] > 0) cnt_m[widx]--;
      ghr_m = {ghr_m[HW-2:0], ut};
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [9:0] e;
    for (int i = 0; i < NE; i++) cnt_m[i] = 1;
    ghr_m = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R7: every entry weakly not-taken, history clear
    for (int a = 0; a < NE; a++) cyc(10'(a), 0, '0, 0, '0, "R7 reset state");

    // R5/R4: train entry 0x155 with history 0 up and into saturation
    e = 10'h155;
    cyc(e, 1, e, 1, 10'h000, "R5 train up");
    cyc(e ^ ghr_m, 0, '0, 0, '0, "R5 count 2 predicts taken");
    for (int k = 0; k < 4; k++) cyc(e ^ ghr_m, 1, e, 1, 10'h000, "R4 saturate high");
    cyc(e ^ ghr_m, 1, e, 0, 10'h000, "R4 one drop from 3");
    cyc(e ^ ghr_m, 0, '0, 0, '0, "R5 count 2 still taken");
    for (int k = 0; k < 5; k++) cyc(e ^ ghr_m, 1, e, 0, 10'h000, "R4 saturate low");
    cyc(e ^ ghr_m, 1, e, 1, 10'h000, "R4 one rise from 0");
    cyc(e ^ ghr_m, 0, '0, 0, '0, "R5 count 1 not taken");

    // R6: returned history differs from live history
    cyc(10'h0F0, 1, 10'h0F0, 1, 10'h30C, "R6 update with old history");
    cyc(10'h0F0, 1, 10'h0F0, 1, 10'h30C, "R6 update with old history");
    cyc(10'h0F0 ^ 10'h30C ^ ghr_m, 0, '0, 0, '0, "R6 trained entry taken");
    cyc(10'h0F0 ^ ghr_m, 0, '0, 0, '0, "R6 live-history entry untouched");

    // R8: same-entry predict and update in one cycle
    e = 10'h2A7;
    cyc(e ^ ghr_m, 1, e ^ 10'h011, 1, 10'h011, "R8 pre-update value");
    cyc(e ^ ghr_m, 0, '0, 0, '0, "R8 post-update value");

    // R2/R3: single-bit address flips select distinct entries
    for (int b = 0; b < AW; b++) begin
      e = 10'h1 << b;
      cyc(e, 1, e, 1, ghr_m, "R2 train bit entry");
      cyc(e, 1, e, 1, ghr_m, "R2 train bit entry");
      cyc(e ^ ghr_m, 0, '0, 0, '0, "R3 xor index");
    end

    // R3/R4/R5/R6: pseudo-random stream, mostly taken
    for (int n = 0; n < 4000; n++) begin
      logic [9:0] ua;
      logic [9:0] uh;
      bit ut;
      lfsr = nxt(lfsr);
      ua = {6'(lfsr[9:4]), 4'(lfsr[3:0])} & 10'h03F;
      ut = (lfsr[13:11] != 3'd0);
      uh = lfsr[14] ? ghr_m : 10'(lfsr[31:22]);
      cyc(10'(lfsr[21:15]) ^ (lfsr[10] ? ghr_m : 10'h000), lfsr[12] | lfsr[16], ua, ut, uh,
          "R3 random stream");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule